// File: doc/BRIEF.md
# DMA Register Access Grant Gate

This block sits in front of the DMA programming registers of a serial flash controller. Software writes 32-bit words to a small window of four registers: a control word, a flash source address, a DRAM target address and a transfer length. Before any of these writes take effect, software must hold a grant. It gets the grant by writing an arm key to the control register and gives it up by writing a disarm key. Any write that arrives without the grant is discarded and flagged by a one-cycle drop pulse.

An accepted control write uses up the grant. If the enable bit of that word is set, the block raises a one-cycle start pulse towards the data mover. During that pulse the latched control, address and length values are valid on dedicated outputs. A build parameter removes the grant requirement. In that build every write in the window is accepted, and the two key words are stored like any other control value.

Register offsets inside the window: control 0x80, flash address 0x84, DRAM address 0x88, length 0x8C.

Top module: `dma_grant_gate`

## Requirements
- R1: Asynchronous reset clears every register, the request flag (control bit 31) and the grant flag (control bit 30); start and drop pulses are low.
- R2: Writing 0xAEED0000 to control (0x80) while the grant is clear sets request and grant together, leaves control bits 29:0 unchanged and raises neither start nor drop.
- R3: Writing 0xDEEA0000 to control clears request and grant, leaves bits 29:0 unchanged and raises neither start nor drop, whether or not the grant was held.
- R4: Before a control write is classified, the current request and grant bits are ORed into it; writing 0xAEED0000 while the grant is held is therefore an ordinary control write and uses up the grant.
- R5: With the grant required and clear, an ordinary control write and any write to 0x84, 0x88 or 0x8C leave all registers unchanged; drop is high for exactly the cycle after that write.
- R6: A granted ordinary control write stores bits 29:0 as written (delay field 11:8 and frequency field 7:4 included) and clears both request and grant; address and length writes do not use up the grant.
- R7: An accepted control write with enable (bit 0) set makes start high for exactly the cycle after the write, with the new control, address and length values on the outputs; with bit 0 clear there is no start.
- R8: The flash address is stored ANDed with 0x0FFFFFFC and the DRAM address ANDed with 0x3FFFFFFC; the length is stored unchanged.
- R9: With the grant requirement off, every write in the window is accepted, drop never rises, and the key words are stored in full as control values (and start if bit 0 is set).
- R10: Reads return the control word (with the flags in bits 31:30) at 0x80 and the stored values at 0x84, 0x88 and 0x8C; every other offset reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one word per cycle |
| wr_addr_i | input | 8 | Byte offset of the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Byte offset of the read |
| rd_data_o | output | 32 | Read data (combinational) |
| req_o | output | 1 | Request flag |
| grant_o | output | 1 | Grant flag |
| drop_o | output | 1 | One-cycle pulse: write rejected for lack of grant |
| start_o | output | 1 | One-cycle pulse: start a transfer |
| ctrl_o | output | 32 | Stored control word, flags included |
| flash_addr_o | output | 32 | Stored flash address |
| dram_addr_o | output | 32 | Stored DRAM address |
| len_o | output | 32 | Stored transfer length |

## Verification
A grant flag stuck or cleared at the wrong moment shows up one cycle after the next write. It appears either as a missing drop pulse on an ungranted write or as a register output that changes when it should hold. Because the key comparison runs on the merged word, a mismatch there shows at once as a grant that survives a control write, or as a control value that flips to a key pattern. Every register output is compared with an independent model after every write. The read port is swept over the whole offset space, so a wrong mask or a wrong decode is seen within a single write-and-read pair.

// File: rtl/dmagate_pkg.sv
package dmagate_pkg;

  typedef enum logic [2:0] {
    WR_IDLE,
    WR_ARM,
    WR_DISARM,
    WR_CTRL,
    WR_FLASH,
    WR_DRAM,
    WR_LEN,
    WR_REJECT
  } wr_kind_e;

  localparam logic [31:0] ARM_KEY    = 32'hAEED_0000;
  localparam logic [31:0] DISARM_KEY = 32'hDEEA_0000;
  localparam int          REQ_POS    = 31;
  localparam int          GNT_POS    = 30;
  localparam int          BODY_W     = 30;

endpackage

// File: rtl/dmagate_decode.sv
module dmagate_decode
  import dmagate_pkg::*;
#(
  parameter int              ADDR_W         = 8,
  parameter bit              GRANT_REQUIRED = 1'b1,
  parameter logic [ADDR_W-1:0] CTRL_OFS     = 'h80,
  parameter logic [ADDR_W-1:0] FLASH_OFS    = 'h84,
  parameter logic [ADDR_W-1:0] DRAM_OFS     = 'h88,
  parameter logic [ADDR_W-1:0] LEN_OFS      = 'h8C
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              req_i,
  input  logic              grant_i,
  output wr_kind_e          kind_o,
  output logic [31:0]       merged_o
);

  logic gate_open;
  logic is_ctrl, is_flash, is_dram, is_len;

  always_comb begin
    merged_o = wr_data_i;
    if (GRANT_REQUIRED) begin
      merged_o[REQ_POS] = wr_data_i[REQ_POS] | req_i;
      merged_o[GNT_POS] = wr_data_i[GNT_POS] | grant_i;
    end
    gate_open = !GRANT_REQUIRED || grant_i;
    is_ctrl   = wr_addr_i == CTRL_OFS;
    is_flash  = wr_addr_i == FLASH_OFS;
    is_dram   = wr_addr_i == DRAM_OFS;
    is_len    = wr_addr_i == LEN_OFS;

    kind_o = WR_IDLE;
    if (wr_en_i) begin
      if (is_ctrl) begin
        if (GRANT_REQUIRED && merged_o == ARM_KEY)         kind_o = WR_ARM;
        else if (GRANT_REQUIRED && merged_o == DISARM_KEY) kind_o = WR_DISARM;
        else if (gate_open)                                kind_o = WR_CTRL;
        else                                               kind_o = WR_REJECT;
      end else if (is_flash) begin
        kind_o = gate_open ? WR_FLASH : WR_REJECT;
      end else if (is_dram) begin
        kind_o = gate_open ? WR_DRAM : WR_REJECT;
      end else if (is_len) begin
        kind_o = gate_open ? WR_LEN : WR_REJECT;
      end
    end
  end

endmodule

// File: rtl/dmagate_regs.sv
module dmagate_regs
  import dmagate_pkg::*;
#(
  parameter bit          GRANT_REQUIRED = 1'b1,
  parameter int          EN_BIT         = 0,
  parameter logic [31:0] FLASH_MASK     = 32'h0FFF_FFFC,
  parameter logic [31:0] DRAM_MASK      = 32'h3FFF_FFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_kind_e          kind_i,
  input  logic [31:0]       merged_i,
  input  logic [31:0]       wr_data_i,
  output logic              req_o,
  output logic              grant_o,
  output logic [BODY_W-1:0] body_o,
  output logic [31:0]       flash_o,
  output logic [31:0]       dram_o,
  output logic [31:0]       len_o,
  output logic              start_o,
  output logic              drop_o
);

  logic              flag_we, ctrl_we, flash_we, dram_we, len_we;
  logic [1:0]        flag_n;
  logic [BODY_W-1:0] body_n;
  logic [31:0]       flash_n, dram_n, len_n;
  logic              start_n, drop_n;

  always_comb begin
    ctrl_we  = kind_i == WR_CTRL;
    flash_we = kind_i == WR_FLASH;
    dram_we  = kind_i == WR_DRAM;
    len_we   = kind_i == WR_LEN;
    flag_we  = ctrl_we || kind_i == WR_ARM || kind_i == WR_DISARM;
    if (kind_i == WR_ARM)                flag_n = 2'b11;
    else if (ctrl_we && !GRANT_REQUIRED) flag_n = {merged_i[REQ_POS], merged_i[GNT_POS]};
    else                                 flag_n = 2'b00;
    body_n  = merged_i[BODY_W-1:0];
    flash_n = wr_data_i & FLASH_MASK;
    dram_n  = wr_data_i & DRAM_MASK;
    len_n   = wr_data_i;
    start_n = ctrl_we && merged_i[EN_BIT];
    drop_n  = kind_i == WR_REJECT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o   <= 1'b0;
      grant_o <= 1'b0;
      body_o  <= '0;
      flash_o <= '0;
      dram_o  <= '0;
      len_o   <= '0;
      start_o <= 1'b0;
      drop_o  <= 1'b0;
    end else begin
      if (flag_we)  {req_o, grant_o} <= flag_n;
      if (ctrl_we)  body_o  <= body_n;
      if (flash_we) flash_o <= flash_n;
      if (dram_we)  dram_o  <= dram_n;
      if (len_we)   len_o   <= len_n;
      start_o <= start_n;
      drop_o  <= drop_n;
    end
  end

  assert_pulse_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && drop_o));

  assert_drop_without_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> !$past(grant_o));

  generate
    if (GRANT_REQUIRED) begin : g_gated_checks
      assert_grant_spent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (!grant_o && !req_o));
      assert_flags_paired_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_o == grant_o);
    end else begin : g_open_checks
      assert_open_never_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_o);
    end
  endgenerate

endmodule

// File: rtl/dmagate_rdmux.sv
module dmagate_rdmux #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 'h80,
  parameter logic [ADDR_W-1:0] FLASH_OFS = 'h84,
  parameter logic [ADDR_W-1:0] DRAM_OFS  = 'h88,
  parameter logic [ADDR_W-1:0] LEN_OFS   = 'h8C
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [31:0]       ctrl_i,
  input  logic [31:0]       flash_i,
  input  logic [31:0]       dram_i,
  input  logic [31:0]       len_i,
  output logic [31:0]       rd_data_o
);

  always_comb begin
    if (rd_addr_i == CTRL_OFS)       rd_data_o = ctrl_i;
    else if (rd_addr_i == FLASH_OFS) rd_data_o = flash_i;
    else if (rd_addr_i == DRAM_OFS)  rd_data_o = dram_i;
    else if (rd_addr_i == LEN_OFS)   rd_data_o = len_i;
    else                             rd_data_o = '0;
  end

endmodule

// File: rtl/dma_grant_gate.sv
module dma_grant_gate
  import dmagate_pkg::*;
#(
  parameter int                ADDR_W         = 8,
  parameter bit                GRANT_REQUIRED = 1'b1,
  parameter int                EN_BIT         = 0,
  parameter logic [31:0]       FLASH_MASK     = 32'h0FFF_FFFC,
  parameter logic [31:0]       DRAM_MASK      = 32'h3FFF_FFFC,
  parameter logic [ADDR_W-1:0] CTRL_OFS       = 'h80,
  parameter logic [ADDR_W-1:0] FLASH_OFS      = 'h84,
  parameter logic [ADDR_W-1:0] DRAM_OFS       = 'h88,
  parameter logic [ADDR_W-1:0] LEN_OFS        = 'h8C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic              req_o,
  output logic              grant_o,
  output logic              drop_o,
  output logic              start_o,
  output logic [31:0]       ctrl_o,
  output logic [31:0]       flash_addr_o,
  output logic [31:0]       dram_addr_o,
  output logic [31:0]       len_o
);

  wr_kind_e          kind;
  logic [31:0]       merged;
  logic [BODY_W-1:0] body;

  dmagate_decode #(
    .ADDR_W(ADDR_W), .GRANT_REQUIRED(GRANT_REQUIRED),
    .CTRL_OFS(CTRL_OFS), .FLASH_OFS(FLASH_OFS), .DRAM_OFS(DRAM_OFS), .LEN_OFS(LEN_OFS)
  ) u_decode (
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .req_i(req_o), .grant_i(grant_o), .kind_o(kind), .merged_o(merged)
  );

  dmagate_regs #(
    .GRANT_REQUIRED(GRANT_REQUIRED), .EN_BIT(EN_BIT),
    .FLASH_MASK(FLASH_MASK), .DRAM_MASK(DRAM_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .kind_i(kind), .merged_i(merged), .wr_data_i(wr_data_i),
    .req_o(req_o), .grant_o(grant_o), .body_o(body), .flash_o(flash_addr_o),
    .dram_o(dram_addr_o), .len_o(len_o), .start_o(start_o), .drop_o(drop_o)
  );

  assign ctrl_o = {req_o, grant_o, body};

  dmagate_rdmux #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .FLASH_OFS(FLASH_OFS),
    .DRAM_OFS(DRAM_OFS), .LEN_OFS(LEN_OFS)
  ) u_rdmux (
    .rd_addr_i(rd_addr_i), .ctrl_i(ctrl_o), .flash_i(flash_addr_o),
    .dram_i(dram_addr_o), .len_i(len_o), .rd_data_o(rd_data_o)
  );

  generate
    if (GRANT_REQUIRED) begin : g_gate_checks
      assert_arm_sets_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == CTRL_OFS && wr_data_i == ARM_KEY && !grant_o)
        |=> (grant_o && req_o && !start_o && !drop_o));
      assert_disarm_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == CTRL_OFS && wr_data_i == DISARM_KEY)
        |=> (!grant_o && !req_o && $stable(ctrl_o[BODY_W-1:0])));
      assert_locked_flash_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == FLASH_OFS && !grant_o) |=> $stable(flash_addr_o));
      assert_granted_ctrl_spends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == CTRL_OFS && grant_o && wr_data_i != DISARM_KEY)
        |=> !grant_o);
    end
  endgenerate

endmodule

// File: tb/tb_dma_grant_gate.sv
module tb_dma_grant_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;

  logic [31:0] rd_data, ctrl, flash, dram, len;
  logic        req, grant, drop, start;
  logic [31:0] o_rd_data, o_ctrl, o_flash, o_dram, o_len;
  logic        o_req, o_grant, o_drop, o_start;

  int checks = 0;
  int errors = 0;

  // models: gated instance and open instance
  logic        e_req, e_grant, e_start, e_drop;
  logic [29:0] e_body;
  logic [31:0] e_flash, e_dram, e_len;
  logic [31:0] m_ctrl, m_flash, m_dram, m_len;
  logic        m_start;

  always #5 clk = ~clk;

  dma_grant_gate dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .req_o(req), .grant_o(grant),
    .drop_o(drop), .start_o(start), .ctrl_o(ctrl), .flash_addr_o(flash),
    .dram_addr_o(dram), .len_o(len)
  );

  dma_grant_gate #(.GRANT_REQUIRED(1'b0)) dut_open (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(o_rd_data), .req_o(o_req), .grant_o(o_grant),
    .drop_o(o_drop), .start_o(o_start), .ctrl_o(o_ctrl), .flash_addr_o(o_flash),
    .dram_addr_o(o_dram), .len_o(o_len)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    e_req = 0; e_grant = 0; e_start = 0; e_drop = 0; e_body = '0;
    e_flash = '0; e_dram = '0; e_len = '0;
    m_ctrl = '0; m_flash = '0; m_dram = '0; m_len = '0; m_start = 0;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " ctrl"},  ctrl,  {e_req, e_grant, e_body});
    chk({tag, " flash"}, flash, e_flash);
    chk({tag, " dram"},  dram,  e_dram);
    chk({tag, " len"},   len,   e_len);
    chk({tag, " start"}, {31'b0, start}, {31'b0, e_start});
    chk({tag, " drop"},  {31'b0, drop},  {31'b0, e_drop});
    chk("R9 open ctrl",  o_ctrl,  m_ctrl);
    chk("R9 open flash", o_flash, m_flash);
    chk("R9 open dram",  o_dram,  m_dram);
    chk("R9 open len",   o_len,   m_len);
    chk("R9 open start", {31'b0, o_start}, {31'b0, m_start});
    chk("R9 open drop",  {31'b0, o_drop},  32'b0);
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    logic [31:0] v;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    // gated model
    e_start = 0; e_drop = 0;
    v = d | {e_req, e_grant, 30'b0};
    case (a)
      8'h80: begin
        if (v == 32'hAEED_0000) begin e_req = 1; e_grant = 1; end
        else if (v == 32'hDEEA_0000) begin e_req = 0; e_grant = 0; end
        else if (!e_grant) e_drop = 1;
        else begin e_body = v[29:0]; e_req = 0; e_grant = 0; e_start = v[0]; end
      end
      8'h84: if (e_grant) e_flash = d & 32'h0FFF_FFFC; else e_drop = 1;
      8'h88: if (e_grant) e_dram = d & 32'h3FFF_FFFC; else e_drop = 1;
      8'h8C: if (e_grant) e_len = d; else e_drop = 1;
      default: ;
    endcase
    // open model
    m_start = 0;
    case (a)
      8'h80: begin m_ctrl = d; m_start = d[0]; end
      8'h84: m_flash = d & 32'h0FFF_FFFC;
      8'h88: m_dram = d & 32'h3FFF_FFFC;
      8'h8C: m_len = d;
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
    check_all(tag);
  endtask

  task automatic read_sweep(input string tag);
    for (int a = 0; a < 256; a += 4) begin
      logic [31:0] eg, eo;
      rd_addr = a[7:0];
      case (a)
        'h80: begin eg = {e_req, e_grant, e_body}; eo = m_ctrl; end
        'h84: begin eg = e_flash; eo = m_flash; end
        'h88: begin eg = e_dram; eo = m_dram; end
        'h8C: begin eg = e_len; eo = m_len; end
        default: begin eg = '0; eo = '0; end
      endcase
      #1;
      chk({tag, " read"}, rd_data, eg);
      chk("R9 open read", o_rd_data, eo);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    #1;
    check_all("R1 reset");
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    #1;
    check_all("R1 reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    read_sweep("R1 R10 after reset");

    // R5 R10: ungranted writes over the whole offset space
    for (int a = 0; a < 256; a += 4) do_wr(a[7:0], 32'hFFFF_FFF1 ^ a, "R5 R10 locked sweep");
    read_sweep("R10 locked");

    // R2 then R8 masks, then R6 plain store with delay/frequency fields
    do_wr(8'h80, 32'hAEED_0000, "R2 arm");
    do_wr(8'h84, 32'hFFFF_FFFF, "R8 flash mask");
    do_wr(8'h88, 32'hFFFF_FFFF, "R8 dram mask");
    do_wr(8'h8C, 32'h0001_2347, "R8 length");
    do_wr(8'h80, 32'h0000_0530, "R6 store no start");
    do_wr(8'h84, 32'h1234_5678, "R5 after spend");
    read_sweep("R6 R10");

    // R7: sweep delay and frequency fields with enable set
    for (int dl = 0; dl < 16; dl++) begin
      for (int fq = 0; fq < 16; fq++) begin
        do_wr(8'h80, 32'hAEED_0000, "R2 rearm");
        do_wr(8'h84, {dl[3:0], fq[3:0], 24'h00_1003}, "R8 flash");
        do_wr(8'h80, {20'h0, dl[3:0], fq[3:0], 4'h1}, "R7 start");
        do_wr(8'h80, {20'h0, dl[3:0], fq[3:0], 4'h1}, "R5 spent");
      end
    end

    // R4: arm key while granted is ordinary and spends the grant
    do_wr(8'h80, 32'hAEED_0000, "R2 arm");
    do_wr(8'h80, 32'hAEED_0000, "R4 key while granted");
    do_wr(8'h80, 32'hAEED_0000, "R2 arm again");
    do_wr(8'h80, 32'h3000_0001, "R4 flag bits merged");

    // R3: disarm with and without grant
    do_wr(8'h80, 32'hAEED_0000, "R2 arm");
    do_wr(8'h80, 32'hDEEA_0000, "R3 disarm granted");
    do_wr(8'h80, 32'hDEEA_0000, "R3 disarm idle");
    do_wr(8'h88, 32'h0000_0040, "R5 after disarm");
    do_wr(8'h80, 32'h0000_0001, "R5 ctrl locked");
    read_sweep("R3 R10");

    // R1: reset in the middle of a granted session
    do_wr(8'h80, 32'hAEED_0000, "R2 arm");
    do_wr(8'h8C, 32'h0000_1000, "R8 length");
    do_reset();
    read_sweep("R1 R10 after mid reset");
    do_wr(8'h84, 32'h0000_0100, "R5 locked after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule